// File: doc/BRIEF.md
# Double-Buffered Register Bank with Atomic Update

This block holds a small set of device settings in two copies. Register writes from a simple strobe port change only the buffered copy. The active copy drives the rest of the chip. An update event moves every buffered entry into its active entry on a single clock edge. Software can therefore stage any number of changes and make them take effect together.

An update starts in one of two ways. Software can set a self-clearing bit in the update register. Hardware can raise an external pin, which is synchronized, edge-detected and gated by an enable bit. A select bit picks whether reads return the buffered or the active copy. Three control registers are written straight through with no buffering. Addresses that the bank does not decode read as zero and drop writes.

Top module: `dbuf_regbank`

## Requirements
- R1: After synchronous reset, buffered entry i (address 0x10+i) and active entry i both hold 0xA0+i, and registers 0x00, 0x04 and 0x05 read 0.
- R2: A write to a buffered address changes what a buffered-mode read of that address returns, and leaves `act_o` unchanged until an update.
- R3: Writing 1 to bit 0 of address 0x05 sets the update bit on that edge; on the next edge every active entry takes its buffered value and the update bit clears, so it reads 0 afterward.
- R4: Several buffered entries written before one update all reach `act_o` on the same edge.
- R5: Bit 0 of address 0x04 selects the read source for buffered addresses: 0 returns the buffered copy, 1 returns the active copy.
- R6: With bit 1 of address 0x04 set, a rising edge on `upd_pin` first sampled at clock edge a updates the active copy at edge a+2.
- R7: With bit 1 of address 0x04 clear, edges on `upd_pin` have no effect on `act_o`.
- R8: One rising edge on `upd_pin` gives exactly one update: holding the pin high does not copy later buffered writes.
- R9: Address 0x00 is unbuffered: a write appears on `cfg_o` right after its write edge and reads back unchanged in either read mode.
- R10: Addresses other than 0x00, 0x04, 0x05 and 0x10 to 0x10+NUM_BUF-1 read as 0, and writes to them change no register.
- R11: A read strobe at edge k gives `rd_data` and a one-cycle `rd_valid` from edge k onward, sampled one cycle later.
- R12: When the update bit and a pin edge fire in the same cycle, a single copy takes place and `act_o` equals the buffered copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | High for the cycle in which rd_data holds a read result |
| upd_pin | input | 1 | Asynchronous external update request, rising-edge active |
| cfg_o | output | DATA_W | Contents of the unbuffered register at 0x00 |
| act_o | output | NUM_BUF*DATA_W | Active copy, entry i at bits i*DATA_W upward |

## Verification
The assertions assume that both strobes are single-cycle pulses with a valid address and that reset is synchronous. `upd_pin` may change at any time, because it passes through the synchronizer before any checked logic sees it. The copy assertion relates the active copy to the buffered copy one cycle before, so it still holds when a buffered write lands on an update edge. The stimulus still never writes a buffered entry in the cycle an update lands. It also keeps `upd_pin` low for at least three cycles before each rising edge, so every intended edge is seen, and it drives every input at the falling clock edge.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  localparam int REG_CFG   = 'h00;
  localparam int REG_RDSEL = 'h04;
  localparam int REG_UPD   = 'h05;

  typedef enum logic {RB_BUFFERED = 1'b0, RB_ACTIVE = 1'b1} rb_src_e;

  function automatic logic [31:0] entry_default(int idx);
    return 32'hA0 + 32'(idx);
  endfunction
endpackage

// File: rtl/dbuf_pin_edge.sv
module dbuf_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] & ~prev_q;

  // R8: one rising edge never yields a pulse two cycles running
  p_pin_one_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/dbuf_ctrl.sv
module dbuf_ctrl #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pin_pulse,
  output logic [DATA_W-1:0] cfg_q,
  output logic [DATA_W-1:0] rdsel_q,
  output logic              upd_bit,
  output logic              upd_fire
);
  import dbuf_pkg::*;
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(REG_CFG);
  localparam logic [ADDR_W-1:0] A_RDSEL = ADDR_W'(REG_RDSEL);
  localparam logic [ADDR_W-1:0] A_UPD   = ADDR_W'(REG_UPD);

  logic set_upd;
  assign set_upd = wr_en && (wr_addr == A_UPD) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      rdsel_q <= '0;
      upd_bit <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CFG)   cfg_q   <= wr_data;
      if (wr_en && wr_addr == A_RDSEL) rdsel_q <= wr_data;
      upd_bit <= set_upd;
    end
  end

  assign upd_fire = upd_bit | (pin_pulse & rdsel_q[1]);

  // R3: the update bit never survives past the cycle after it was set
  p_selfclear_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_bit && !set_upd) |=> !upd_bit);
endmodule

// File: rtl/dbuf_store.sv
module dbuf_store #(
  parameter int DATA_W  = 8,
  parameter int NUM_BUF = 8,
  parameter int IDX_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      upd_i,
  output logic [NUM_BUF*DATA_W-1:0] shad_flat,
  output logic [NUM_BUF*DATA_W-1:0] act_flat
);
  import dbuf_pkg::*;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_entry
    localparam logic [DATA_W-1:0] DFLT = DATA_W'(entry_default(g));
    logic [DATA_W-1:0] sh_q, ac_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_q <= DFLT;
        ac_q <= DFLT;
      end else begin
        if (wr_en && wr_idx == IDX_W'(g)) sh_q <= wr_data;
        if (upd_i) ac_q <= sh_q;
      end
    end
    assign shad_flat[g*DATA_W +: DATA_W] = sh_q;
    assign act_flat[g*DATA_W +: DATA_W]  = ac_q;
  end

  // R2: the active copy stays put without an update
  p_active_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> $stable(act_flat));
  // R4: an update moves the whole buffered copy at once
  p_atomic_copy_r4: assert property (@(posedge clk) disable iff (rst)
    upd_i |=> act_flat == $past(shad_flat));
endmodule

// File: rtl/dbuf_regbank.sv
module dbuf_regbank #(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int NUM_BUF  = 8,
  parameter int BUF_BASE = 'h10,
  parameter int SYNC_N   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      rd_valid,
  input  logic                      upd_pin,
  output logic [DATA_W-1:0]         cfg_o,
  output logic [NUM_BUF*DATA_W-1:0] act_o
);
  import dbuf_pkg::*;
  localparam int IDX_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(BUF_BASE);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(NUM_BUF);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(REG_CFG);
  localparam logic [ADDR_W-1:0] A_RDSEL = ADDR_W'(REG_RDSEL);
  localparam logic [ADDR_W-1:0] A_UPD   = ADDR_W'(REG_UPD);

  logic                      pin_pulse, upd_bit, upd_fire;
  logic [DATA_W-1:0]         cfg_q, rdsel_q;
  logic [NUM_BUF*DATA_W-1:0] shad_flat, act_flat;
  logic [ADDR_W-1:0]         wr_off, rd_off;
  logic                      wr_hit, rd_hit, rd_mapped;
  logic [IDX_W-1:0]          rd_idx;
  logic [DATA_W-1:0]         rd_mux;
  rb_src_e                   rb_src;

  assign wr_off = wr_addr - A_BASE;
  assign rd_off = rd_addr - A_BASE;
  assign wr_hit = (wr_addr >= A_BASE) && (wr_off < A_CNT);
  assign rd_hit = (rd_addr >= A_BASE) && (rd_off < A_CNT);
  assign rd_idx = rd_off[IDX_W-1:0];
  assign rb_src = rb_src_e'(rdsel_q[0]);

  dbuf_pin_edge #(.STAGES(SYNC_N)) i_pin (
    .clk(clk), .rst(rst), .pin_i(upd_pin), .pulse_o(pin_pulse));

  dbuf_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pin_pulse(pin_pulse), .cfg_q(cfg_q),
    .rdsel_q(rdsel_q), .upd_bit(upd_bit), .upd_fire(upd_fire));

  dbuf_store #(.DATA_W(DATA_W), .NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) i_store (
    .clk(clk), .rst(rst), .wr_en(wr_en && wr_hit),
    .wr_idx(wr_off[IDX_W-1:0]), .wr_data(wr_data), .upd_i(upd_fire),
    .shad_flat(shad_flat), .act_flat(act_flat));

  always_comb begin
    rd_mux    = '0;
    rd_mapped = 1'b1;
    if (rd_addr == A_CFG)        rd_mux = cfg_q;
    else if (rd_addr == A_RDSEL) rd_mux = rdsel_q;
    else if (rd_addr == A_UPD)   rd_mux = {{(DATA_W-1){1'b0}}, upd_bit};
    else if (rd_hit)
      rd_mux = (rb_src == RB_ACTIVE) ? act_flat[int'(rd_idx)*DATA_W +: DATA_W]
                                     : shad_flat[int'(rd_idx)*DATA_W +: DATA_W];
    else rd_mapped = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  assign cfg_o = cfg_q;
  assign act_o = act_flat;

  // R10: an undecoded read returns zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_mapped) |=> rd_data == '0);
  // R11: every read strobe is answered on the following cycle
  p_read_valid_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  // R7: with the pin disabled and no update bit, the active copy holds
  p_pin_gated_r7: assert property (@(posedge clk) disable iff (rst)
    (!rdsel_q[1] && !upd_bit) |=> $stable(act_o));
endmodule

// File: tb/test_dbuf_regbank.sv
`timescale 1ns/1ps
module test_dbuf_regbank;
  localparam int AW = 13, DW = 8, NB = 8, BASE = 'h10;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0, upd_pin = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data, cfg_o;
  logic rd_valid;
  logic [NB*DW-1:0] act_o;

  int checks = 0, fails = 0;
  logic [DW-1:0] m_sh [NB];
  logic [DW-1:0] m_ac [NB];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #2.5 clk = ~clk;

  dbuf_regbank #(.ADDR_W(AW), .DATA_W(DW), .NUM_BUF(NB), .BUF_BASE(BASE)) i_dbuf_regbank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .upd_pin(upd_pin), .cfg_o(cfg_o), .act_o(act_o));

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int a, logic [DW-1:0] e, string tag);
    @(negedge clk);
    rd_en = 1; rd_addr = AW'(a);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_act(string tag);
    for (int i = 0; i < NB; i++) check(tag, act_o[i*DW +: DW], m_ac[i]);
  endtask

  function automatic void model_copy();
    for (int i = 0; i < NB; i++) m_ac[i] = m_sh[i];
  endfunction

  // scoreboard monitor: R11 read result one cycle after the strobe
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 unexpected rd_valid actual=1 expected=0");
      end else begin
        string t;
        logic [DW-1:0] e;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin m_sh[i] = DW'(8'hA0 + i); m_ac[i] = m_sh[i]; end
    tick(3); rst = 0; tick(1);

    // R1 reset state
    chk_act("R1 active default");
    rd(BASE + 3, 8'hA3, "R1 buffered default");
    rd('h00, 8'h00, "R1 reg00");
    rd('h04, 8'h00, "R1 reg04");
    rd('h05, 8'h00, "R1 reg05");

    // R2 buffered write only
    wr(BASE + 2, 8'h55); m_sh[2] = 8'h55;
    rd(BASE + 2, 8'h55, "R2 buffered readback");
    chk_act("R2 active unchanged");

    // R5 read source select
    wr('h04, 8'h01);
    rd(BASE + 2, 8'hA2, "R5 active readback");
    wr('h04, 8'h00);
    rd(BASE + 2, 8'h55, "R5 buffered readback");

    // R4 + R3 staged writes then self-clearing update
    wr(BASE + 0, 8'h11); m_sh[0] = 8'h11;
    wr(BASE + 7, 8'h77); m_sh[7] = 8'h77;
    chk_act("R4 nothing before update");
    wr('h05, 8'h01);
    check("R3 bit set", act_o[2*DW +: DW], 8'hA2);
    model_copy();
    rd('h05, 8'h00, "R3 selfclear");
    chk_act("R4 all moved together");

    // R9 unbuffered config
    wr('h00, 8'h3C);
    check("R9 cfg_o immediate", cfg_o, 8'h3C);
    wr('h04, 8'h01);
    rd('h00, 8'h3C, "R9 readback active mode");
    wr('h04, 8'h00);
    rd('h00, 8'h3C, "R9 readback buffered mode");

    // R10 unmapped
    wr('h01, 8'hFF); wr(BASE - 1, 8'hFF); wr(BASE + NB, 8'hFF);
    rd('h01, 8'h00, "R10 addr01");
    rd(BASE - 1, 8'h00, "R10 below base");
    rd(BASE + NB, 8'h00, "R10 above bank");
    rd(BASE + 7, 8'h77, "R10 no wrap");
    rd('h00, 8'h3C, "R10 cfg intact");
    chk_act("R10 active intact");

    // R7 pin disabled
    wr(BASE + 1, 8'h99); m_sh[1] = 8'h99;
    upd_pin = 1; tick(5); upd_pin = 0; tick(4);
    chk_act("R7 pin disabled");

    // R6 pin enabled, update lands at edge a+2
    wr('h04, 8'h02);
    tick(1); upd_pin = 1;
    tick(2); chk_act("R6 not yet");
    tick(1); model_copy(); chk_act("R6 pin update");

    // R8 held pin gives no second update
    wr(BASE + 1, 8'h5A); m_sh[1] = 8'h5A;
    tick(6); chk_act("R8 single update");
    upd_pin = 0; tick(4);

    // R12 both sources in the same cycle
    wr(BASE + 5, 8'hC5); m_sh[5] = 8'hC5;
    tick(1); upd_pin = 1;
    wr('h05, 8'h01);
    tick(1); model_copy(); chk_act("R12 both sources");
    rd('h05, 8'h00, "R12 bit cleared");
    upd_pin = 0; tick(4);
    chk_act("R12 no extra copy");

    // R5 + R11 full active readback
    wr('h04, 8'h01);
    for (int i = 0; i < NB; i++) rd(BASE + i, m_ac[i], "R5 active sweep");
    tick(2);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11 pending reads actual=%0d expected=0", exp_q.size());
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule